// File: doc/BRIEF.md
# Exception Acceptance and Vectoring Unit

This block sits beside a processor's exception sequencer and decides, once per clock, which of the pending events is taken. The events are a reset event, a general exception (with a TLB-error qualifier), a user break, a DMA address error and an interrupt. Whether an event is taken depends on the status block bit. Each event class has its own policy while that bit is set: it is held, discarded, turned into a forced jump to the fixed reset vector, or taken anyway when the core is in low-power mode.

For every accepted event the block reports, one cycle after the request, the handler address and a 12-bit event code. It also reports which event register the code belongs in and a command to set the block bit. The handler address is the vector base plus a class offset. Held requests wait in sticky pending flags. The block treats the cycle right after an acceptance as blocked, so it never takes two events back to back before the core has set the bit.

Top module: `exc_accept_unit`

## Requirements
- R1: A reset event is taken whatever the block bit is and ahead of every other request. One cycle later the unit reports target 0xA0000000, code 0x000 and code destination 2'b01 (exception-event register).
- R2: An unblocked general exception without the TLB qualifier produces target VBR+0x100, the request's code and destination 2'b01.
- R3: An unblocked general exception with the TLB qualifier set produces target VBR+0x400.
- R4: An unblocked interrupt produces target VBR+0x600, its code and destination 2'b10 (interrupt-event register).
- R5: Every acceptance raises `accept` and `set_block` together, one cycle after the request is sampled. At most one event is accepted per cycle. The unit treats the cycle after an acceptance as blocked, even if the `block` input is 0.
- R6: An interrupt that arrives while the unit is blocked and not in low-power mode is held. It is taken after the block clears, with its original code. A second interrupt that arrives while one is held does not replace the held code.
- R7: While blocked with `low_power` high, a pending interrupt is accepted and `wake` is 1 with it. `wake` is 1 only on accepted interrupts taken with `low_power` high.
- R8: A DMA address error that arrives while blocked is held and is taken after the block clears: target VBR+0x100, held code, destination 2'b01.
- R9: A user break that arrives while blocked is discarded and is never taken later. An unblocked user break produces VBR+0x100, its code and destination 2'b01.
- R10: A general exception while blocked is a multiple exception. The unit reports `accept`, `multi_exc`, target 0xA0000000, code 0 and destination 2'b00 (no event register written).
- R11: The priority order is reset, then general exception, then user break, then DMA error, then interrupt. A losing general exception or break is dropped. A losing DMA error or interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears pending flags and outputs |
| vbr | input | 32 | Vector base address |
| block | input | 1 | Status block bit |
| low_power | input | 1 | Core is in low-power mode |
| req_reset | input | 1 | Reset event request |
| req_gen | input | 1 | General exception request |
| gen_tlb | input | 1 | General exception is a TLB error |
| gen_code | input | 12 | General exception code |
| req_brk | input | 1 | User break request |
| brk_code | input | 12 | User break code |
| req_dma | input | 1 | DMA address error request |
| dma_code | input | 12 | DMA address error code |
| req_int | input | 1 | Interrupt request |
| int_code | input | 12 | Interrupt code |
| accept | output | 1 | An event was accepted |
| target | output | 32 | Handler address |
| code | output | 12 | Event code |
| code_dst | output | 2 | 00 none, 01 exception-event register, 10 interrupt-event register |
| set_block | output | 1 | Command to set the block bit |
| wake | output | 1 | Interrupt accepted in low-power mode |
| multi_exc | output | 1 | Multiple-exception jump to the reset vector |

## Verification
The hardest state to reach is a held interrupt or DMA error that meets a new request of the same class, a low-power wake and a higher-priority event, all at once. The implicit block in the cycle after each acceptance adds to this. Directed sequences set up a held interrupt and then release it under low power, under a competing DMA error and under a duplicate request. A long seeded random phase keeps the block bit high about a third of the time, so pending flags build up and drain through many mixes. A cycle-level model in the bench tracks the pending state and predicts every output.

// File: rtl/exc_accept_pkg.sv
package exc_accept_pkg;
   typedef enum logic [2:0] {
      EV_NONE  = 3'd0,
      EV_RST   = 3'd1,
      EV_MULTI = 3'd2,
      EV_GEN   = 3'd3,
      EV_BRK   = 3'd4,
      EV_DMA   = 3'd5,
      EV_INT   = 3'd6
   } ev_sel_e;

   typedef enum logic [1:0] {
      DST_NONE = 2'b00,
      DST_EXC  = 2'b01,
      DST_INT  = 2'b10
   } code_dst_e;

   localparam int SLOT_DMA  = 0;
   localparam int SLOT_INT  = 1;
   localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/exc_pend_slot.sv
module exc_pend_slot #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              take_i,
   output logic              valid_o,
   output logic [CODE_W-1:0] code_o
);
   logic              pend_q;
   logic [CODE_W-1:0] pcode_q;

   // a held request is older than a fresh one, so its code wins
   assign valid_o = req_i | pend_q;
   assign code_o  = pend_q ? pcode_q : code_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         pcode_q <= '0;
      end else begin
         pend_q <= valid_o & ~take_i;
         if (req_i && !pend_q)
            pcode_q <= code_i;
      end
   end

   // R6, R8: a pending flag drops only when its request was taken
   assert_pend_clears_on_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q) |-> $past(take_i));
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_accept_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 blocked,
   input  logic                 low_power,
   input  logic                 req_reset,
   input  logic                 req_gen,
   input  logic                 req_brk,
   input  logic [NUM_SLOTS-1:0] slot_valid,
   output ev_sel_e              sel,
   output logic [NUM_SLOTS-1:0] take
);
   always_comb begin
      sel  = EV_NONE;
      take = '0;
      if (req_reset) begin
         sel = EV_RST;
      end else if (req_gen) begin
         sel = blocked ? EV_MULTI : EV_GEN;
      end else if (req_brk && !blocked) begin
         sel = EV_BRK;
      end else if (slot_valid[SLOT_DMA] && !blocked) begin
         sel            = EV_DMA;
         take[SLOT_DMA] = 1'b1;
      end else if (slot_valid[SLOT_INT] && (!blocked || low_power)) begin
         sel            = EV_INT;
         take[SLOT_INT] = 1'b1;
      end
   end

   // R11: at most one retained slot drained per cycle
   assert_single_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take));
   // R11: a drained slot never coexists with a higher class request
   assert_take_yields_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (|take) |-> !(req_reset || req_gen));
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
   import exc_accept_pkg::*;
#(
   parameter int                  ADDR_W        = 32,
   parameter int                  CODE_W        = 12,
   parameter logic [ADDR_W-1:0]   OFS_GEN       = 'h100,
   parameter logic [ADDR_W-1:0]   OFS_TLB       = 'h400,
   parameter logic [ADDR_W-1:0]   OFS_INT       = 'h600,
   parameter logic [ADDR_W-1:0]   RST_VEC       = 'hA000_0000,
   parameter int                  VBR_ZERO_LSBS = 0
) (
   input  ev_sel_e           sel,
   input  logic [ADDR_W-1:0] vbr,
   input  logic              gen_tlb,
   input  logic [CODE_W-1:0] gen_code,
   input  logic [CODE_W-1:0] brk_code,
   input  logic [CODE_W-1:0] dma_code,
   input  logic [CODE_W-1:0] int_code,
   output logic [ADDR_W-1:0] target,
   output logic [CODE_W-1:0] code,
   output code_dst_e         dst
);
   logic [ADDR_W-1:0] ofs;
   logic [ADDR_W-1:0] based;

   always_comb begin
      unique case (sel)
         EV_GEN:  ofs = gen_tlb ? OFS_TLB : OFS_GEN;
         EV_INT:  ofs = OFS_INT;
         default: ofs = OFS_GEN;
      endcase
   end

   generate
      if (VBR_ZERO_LSBS > 0) begin : g_or_base
         // base is aligned, so merging the offset needs no carry chain
         if (VBR_ZERO_LSBS < ADDR_W) begin : g_chk
            if ((OFS_GEN >> VBR_ZERO_LSBS) != 0 || (OFS_TLB >> VBR_ZERO_LSBS) != 0 ||
                (OFS_INT >> VBR_ZERO_LSBS) != 0) begin : g_bad
               $error("offsets exceed aligned base low bits");
            end
         end
         assign based = vbr | ofs;
      end else begin : g_add_base
         assign based = vbr + ofs;
      end
   endgenerate

   always_comb begin
      target = '0;
      code   = '0;
      dst    = DST_NONE;
      unique case (sel)
         EV_RST:   begin target = RST_VEC; dst = DST_EXC; end
         EV_MULTI: begin target = RST_VEC; end
         EV_GEN:   begin target = based; code = gen_code; dst = DST_EXC; end
         EV_BRK:   begin target = based; code = brk_code; dst = DST_EXC; end
         EV_DMA:   begin target = based; code = dma_code; dst = DST_EXC; end
         EV_INT:   begin target = based; code = int_code; dst = DST_INT; end
         default:  begin target = '0; end
      endcase
   end
endmodule

// File: rtl/exc_accept_unit.sv
module exc_accept_unit
   import exc_accept_pkg::*;
#(
   parameter int                ADDR_W        = 32,
   parameter int                CODE_W        = 12,
   parameter logic [ADDR_W-1:0] OFS_GEN       = 'h100,
   parameter logic [ADDR_W-1:0] OFS_TLB       = 'h400,
   parameter logic [ADDR_W-1:0] OFS_INT       = 'h600,
   parameter logic [ADDR_W-1:0] RST_VEC       = 'hA000_0000,
   parameter int                VBR_ZERO_LSBS = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] vbr,
   input  logic              block,
   input  logic              low_power,
   input  logic              req_reset,
   input  logic              req_gen,
   input  logic              gen_tlb,
   input  logic [CODE_W-1:0] gen_code,
   input  logic              req_brk,
   input  logic [CODE_W-1:0] brk_code,
   input  logic              req_dma,
   input  logic [CODE_W-1:0] dma_code,
   input  logic              req_int,
   input  logic [CODE_W-1:0] int_code,
   output logic              accept,
   output logic [ADDR_W-1:0] target,
   output logic [CODE_W-1:0] code,
   output logic [1:0]        code_dst,
   output logic              set_block,
   output logic              wake,
   output logic              multi_exc
);
   localparam int NS = NUM_SLOTS;

   generate
      if (CODE_W < 1 || CODE_W > ADDR_W) begin : g_bad_code_w
         $error("CODE_W must lie in 1..ADDR_W");
      end
      if (ADDR_W < 12) begin : g_bad_addr_w
         $error("ADDR_W too small for vector offsets");
      end
   endgenerate

   logic                    eff_blk;
   logic [NS-1:0]           s_req;
   logic [NS-1:0][CODE_W-1:0] s_code_in;
   logic [NS-1:0]           s_valid;
   logic [NS-1:0][CODE_W-1:0] s_code;
   logic [NS-1:0]           s_take;
   ev_sel_e                 sel;
   logic [ADDR_W-1:0]       tgt_d;
   logic [CODE_W-1:0]       code_d;
   code_dst_e               dst_d;
   logic                    acc_d;

   // the cycle after an acceptance counts as blocked
   assign eff_blk = block | set_block;

   assign s_req[SLOT_DMA]     = req_dma;
   assign s_req[SLOT_INT]     = req_int;
   assign s_code_in[SLOT_DMA] = dma_code;
   assign s_code_in[SLOT_INT] = int_code;

   generate
      for (genvar i = 0; i < NS; i++) begin : g_slot
         exc_pend_slot #(.CODE_W(CODE_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (s_req[i]),
            .code_i  (s_code_in[i]),
            .take_i  (s_take[i]),
            .valid_o (s_valid[i]),
            .code_o  (s_code[i])
         );
      end
   endgenerate

   exc_arbiter u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .blocked    (eff_blk),
      .low_power  (low_power),
      .req_reset  (req_reset),
      .req_gen    (req_gen),
      .req_brk    (req_brk),
      .slot_valid (s_valid),
      .sel        (sel),
      .take       (s_take)
   );

   exc_vector_gen #(
      .ADDR_W        (ADDR_W),
      .CODE_W        (CODE_W),
      .OFS_GEN       (OFS_GEN),
      .OFS_TLB       (OFS_TLB),
      .OFS_INT       (OFS_INT),
      .RST_VEC       (RST_VEC),
      .VBR_ZERO_LSBS (VBR_ZERO_LSBS)
   ) u_vec (
      .sel      (sel),
      .vbr      (vbr),
      .gen_tlb  (gen_tlb),
      .gen_code (gen_code),
      .brk_code (brk_code),
      .dma_code (s_code[SLOT_DMA]),
      .int_code (s_code[SLOT_INT]),
      .target   (tgt_d),
      .code     (code_d),
      .dst      (dst_d)
   );

   assign acc_d = (sel != EV_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accept    <= 1'b0;
         target    <= '0;
         code      <= '0;
         code_dst  <= DST_NONE;
         set_block <= 1'b0;
         wake      <= 1'b0;
         multi_exc <= 1'b0;
      end else begin
         accept    <= acc_d;
         target    <= tgt_d;
         code      <= code_d;
         code_dst  <= dst_d;
         set_block <= acc_d;
         wake      <= (sel == EV_INT) && low_power;
         multi_exc <= (sel == EV_MULTI);
      end
   end

   assert_reset_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_reset |=> (accept && target == RST_VEC && code_dst == DST_EXC));
   assert_multi_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_blk && req_gen && !req_reset) |=>
         (multi_exc && code_dst == DST_NONE && target == RST_VEC));
   assert_wake_is_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (accept && code_dst == DST_INT));
   assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_reset && !req_gen && !low_power) |=> !accept);
   assert_brk_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_blk && req_brk && !req_reset && !req_gen && !low_power) |=> !accept);
endmodule

// File: tb/exc_accept_unit_tb.sv
module exc_accept_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] vbr = '0;
   logic        block = 1'b0, low_power = 1'b0;
   logic        req_reset = 1'b0, req_gen = 1'b0, gen_tlb = 1'b0;
   logic        req_brk = 1'b0, req_dma = 1'b0, req_int = 1'b0;
   logic [11:0] gen_code = '0, brk_code = '0, dma_code = '0, int_code = '0;
   logic        accept, set_block, wake, multi_exc;
   logic [31:0] target;
   logic [11:0] code;
   logic [1:0]  code_dst;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model state
   bit          m_pi, m_pd, m_blk;
   logic [11:0] m_pic, m_pdc;

   always #4 clk = ~clk;

   exc_accept_unit u_dut (
      .clk(clk), .rst_n(rst_n), .vbr(vbr), .block(block), .low_power(low_power),
      .req_reset(req_reset), .req_gen(req_gen), .gen_tlb(gen_tlb), .gen_code(gen_code),
      .req_brk(req_brk), .brk_code(brk_code), .req_dma(req_dma), .dma_code(dma_code),
      .req_int(req_int), .int_code(int_code),
      .accept(accept), .target(target), .code(code), .code_dst(code_dst),
      .set_block(set_block), .wake(wake), .multi_exc(multi_exc));

   task automatic step();
      bit          eb, vi, vd, e_acc, e_wake, e_multi, tk_i, tk_d;
      logic [11:0] ci, cd, e_code;
      logic [31:0] e_tgt;
      logic [1:0]  e_dst;
      string       tag;
      int          nreq;
      eb = block | m_blk;
      vi = req_int | m_pi;  ci = m_pi ? m_pic : int_code;
      vd = req_dma | m_pd;  cd = m_pd ? m_pdc : dma_code;
      e_acc = 1; e_wake = 0; e_multi = 0; tk_i = 0; tk_d = 0;
      e_tgt = 0; e_code = 0; e_dst = 2'b00;
      nreq = int'(req_reset) + int'(req_gen) + int'(req_brk) + int'(vd) + int'(vi);
      if (req_reset) begin
         e_tgt = 32'hA000_0000; e_dst = 2'b01; tag = "R1";
      end else if (req_gen && eb) begin
         e_tgt = 32'hA000_0000; e_multi = 1; tag = "R10";
      end else if (req_gen) begin
         e_tgt = vbr + (gen_tlb ? 32'h400 : 32'h100); e_code = gen_code; e_dst = 2'b01;
         tag = gen_tlb ? "R3" : "R2";
      end else if (req_brk && !eb) begin
         e_tgt = vbr + 32'h100; e_code = brk_code; e_dst = 2'b01; tag = "R9";
      end else if (vd && !eb) begin
         e_tgt = vbr + 32'h100; e_code = cd; e_dst = 2'b01; tk_d = 1; tag = "R8";
      end else if (vi && (!eb || low_power)) begin
         e_tgt = vbr + 32'h600; e_code = ci; e_dst = 2'b10; tk_i = 1;
         e_wake = low_power; tag = low_power ? "R7" : "R4";
      end else begin
         e_acc = 0;
         tag = req_brk ? "R9" : (vd ? "R8" : (vi ? "R6" : "R5"));
      end
      if (nreq > 1) tag = "R11";
      if (!m_pd && req_dma) m_pdc = dma_code;
      if (!m_pi && req_int) m_pic = int_code;
      m_pd = vd & ~tk_d;
      m_pi = vi & ~tk_i;
      m_blk = e_acc;
      @(posedge clk);
      @(negedge clk);
      n_checks++;
      if (accept !== e_acc || set_block !== e_acc || target !== e_tgt || code !== e_code ||
          code_dst !== e_dst || wake !== e_wake || multi_exc !== e_multi) begin
         n_fail++;
         $display("FAIL %s: acc=%0b sb=%0b tgt=%h code=%h dst=%0d wake=%0b multi=%0b expected acc=%0b sb=%0b tgt=%h code=%h dst=%0d wake=%0b multi=%0b",
                  tag, accept, set_block, target, code, code_dst, wake, multi_exc,
                  e_acc, e_acc, e_tgt, e_code, e_dst, e_wake, e_multi);
      end
   endtask

   task automatic idle_in();
      req_reset = 0; req_gen = 0; gen_tlb = 0; req_brk = 0; req_dma = 0; req_int = 0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7711));
      m_pi = 0; m_pd = 0; m_blk = 0; m_pic = 0; m_pdc = 0;
      repeat (3) @(negedge clk);
      n_checks++;  // reset state, R5
      if (accept !== 0 || set_block !== 0 || code_dst !== 2'b00 || target !== 0) begin
         n_fail++;
         $display("FAIL R5 reset: acc=%0b tgt=%h expected acc=0 tgt=0", accept, target);
      end
      rst_n = 1;
      @(negedge clk);
      vbr = 32'h8000_1000;
      // R2, R3 plain general exceptions
      req_gen = 1; gen_code = 12'h0E0; step(); idle_in(); step();
      req_gen = 1; gen_tlb = 1; gen_code = 12'h040; step(); idle_in(); step();
      // R4 interrupt
      req_int = 1; int_code = 12'h3A0; step(); idle_in(); step();
      // R6 held interrupt, then duplicate, then release
      block = 1; req_int = 1; int_code = 12'h520; step();
      int_code = 12'h540; step(); idle_in(); step();
      block = 0; step(); step();
      // R7 low-power wake while blocked
      block = 1; low_power = 1; req_int = 1; int_code = 12'h600; step(); idle_in();
      low_power = 0; step();
      // R8 held DMA error competing with held interrupt (R11)
      req_dma = 1; dma_code = 12'h5C0; req_int = 1; int_code = 12'h620; step(); idle_in();
      step(); block = 0; step(); step(); step();
      // R9 break dropped while blocked, not taken later
      block = 1; req_brk = 1; brk_code = 12'h1E0; step(); idle_in(); block = 0;
      step(); step();
      req_brk = 1; step(); idle_in(); step();
      // R10 multiple exception; R1 reset beats all
      block = 1; req_gen = 1; gen_code = 12'h160; step(); idle_in(); block = 0; step();
      req_reset = 1; req_gen = 1; req_int = 1; step(); idle_in(); step(); step();
      // seeded random phase
      for (int k = 0; k < 3000; k++) begin
         if ($urandom_range(15) == 0) vbr = $urandom;
         block     = ($urandom_range(2) == 0);
         low_power = ($urandom_range(4) == 0);
         req_reset = ($urandom_range(39) == 0);
         req_gen   = ($urandom_range(7) == 0);
         gen_tlb   = $urandom_range(1);
         req_brk   = ($urandom_range(7) == 0);
         req_dma   = ($urandom_range(5) == 0);
         req_int   = ($urandom_range(3) == 0);
         gen_code  = 12'($urandom); brk_code = 12'($urandom);
         dma_code  = 12'($urandom); int_code = 12'($urandom);
         step();
      end
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule